// File: doc/BRIEF.md
# DDR Address and Command Rate Converter

This block sits between a memory controller and the command pins of a DDR SDRAM. It runs entirely on the memory clock, which is twice the controller clock and phase-aligned with it. An internal phase toggle splits each controller cycle into a first and a second memory cycle. The phase is brought out so that the controller side can align to it.

In half-rate mode the controller holds one command for a whole controller cycle. The block captures that command at the end of the second memory cycle. It then presents address, bank address and the row, column and write strobes for two memory cycles (2T). Chip select, clock enable and on-die termination are pulsed for a single memory cycle (1T), placed in the second cycle of the 2T window. The address is therefore already stable for a full cycle before chip select goes low. Half-rate operation implies bursts of four on the memory side, so each controller command carries one burst.

In full-rate mode every output follows the inputs with one memory cycle of latency and lasts one cycle. When no chip select is requested, the strobes are forced high so that the bus carries a NOP.

Top module: `ddr_cmd_rate_conv`

## Requirements
- R1: `phase_o` is 0 during reset and in the first memory cycle after reset is released. It then toggles on every memory clock. A value of 0 marks the first memory cycle of a controller cycle and 1 marks the second.
- R2: In half-rate mode (`half_rate_i`=1), the inputs `addr_i`, `ba_i` and the strobes present in a memory cycle with `phase_o`=1 appear on `mem_addr_o`, `mem_ba_o` and the strobe outputs in the next two memory cycles (phase 0, then phase 1). They are identical in both of those cycles.
- R3: In half-rate mode, `mem_cs_n_o` (active low), `mem_cke_o` and `mem_odt_o` (active high) are inactive in the phase-0 cycle of the output window. In the phase-1 cycle they carry the captured request (`mem_cs_n_o` = ~`cs_req_i`, with `cs_req_i` active high per rank). No bit is active in two consecutive cycles.
- R4: In half-rate mode, input values present only during a phase-0 memory cycle have no effect on the outputs. Only the values held at the end of the phase-1 cycle are used.
- R5: In full-rate mode (`half_rate_i`=0), every output equals the corresponding input of the previous memory cycle. Chip select is inverted, and each value lasts a single memory cycle.
- R6: When no bit of `cs_req_i` is set, `mem_ras_n_o`, `mem_cas_n_o` and `mem_we_n_o` are driven 1 and `mem_cs_n_o` is all ones, whatever the strobe inputs are.
- R7: During reset, `mem_cs_n_o` is all ones, `mem_cke_o` and `mem_odt_o` are zero, the strobes are 1, the address and bank outputs are zero and `phase_o` is 0.
- R8: In half-rate mode, commands issued in consecutive controller cycles appear back to back. Each address holds for two cycles, and chip select pulses low in every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mem_i | input | 1 | Memory clock (twice the controller clock) |
| rst_i | input | 1 | Synchronous reset, active high |
| half_rate_i | input | 1 | 1 selects half-rate (mixed 2T/1T), 0 selects full-rate (all 1T) |
| cs_req_i | input | RANKS | Chip select request per rank, active high |
| ras_n_i | input | 1 | Row strobe from controller, active low |
| cas_n_i | input | 1 | Column strobe from controller, active low |
| we_n_i | input | 1 | Write strobe from controller, active low |
| addr_i | input | ADDR_W | Address from controller |
| ba_i | input | BA_W | Bank address from controller |
| cke_i | input | RANKS | Clock enable request per rank |
| odt_i | input | RANKS | On-die termination request per rank |
| phase_o | output | 1 | Memory cycle phase within the controller cycle |
| mem_cs_n_o | output | RANKS | Chip select to memory, active low |
| mem_cke_o | output | RANKS | Clock enable to memory |
| mem_odt_o | output | RANKS | On-die termination to memory |
| mem_ras_n_o | output | 1 | Row strobe to memory |
| mem_cas_n_o | output | 1 | Column strobe to memory |
| mem_we_n_o | output | 1 | Write strobe to memory |
| mem_addr_o | output | ADDR_W | Address to memory |
| mem_ba_o | output | BA_W | Bank address to memory |

## Verification
In half-rate mode, two functions meet in one memory cycle: the 2T lanes capture the next command, and the 1T lanes issue the chip select of the current one. Both happen in the phase-1 cycle. The back-to-back scenario provokes this by presenting a second command while the first command's chip select is low. The test passes only if the first address is still on the bus with chip select low in that cycle, and the second address appears the following cycle with chip select high. A separate scenario changes the inputs during phase 0 and then restores them, to show that only the phase-1 values reach the pins.

// File: rtl/ddr_rc_pkg.sv
package ddr_rc_pkg;

   // Memory cycle position inside one controller cycle
   typedef enum logic {
      SLOT_FIRST  = 1'b0,
      SLOT_SECOND = 1'b1
   } slot_e;

   localparam int STROBE_W = 3;

   function automatic slot_e next_slot(input slot_e cur);
      return (cur == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
   endfunction

endpackage

// File: rtl/ddr_rc_phase.sv
module ddr_rc_phase
   import ddr_rc_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_i,
   output slot_e ph_o
);

   slot_e ph_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ph_q <= SLOT_FIRST;
      end else begin
         ph_q <= next_slot(ph_q);
      end
   end

   assign ph_o = ph_q;

   // R1
   phase_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$past(rst_i) |-> (ph_q != $past(ph_q)));

endmodule

// File: rtl/ddr_rc_lane2t.sv
module ddr_rc_lane2t
   import ddr_rc_pkg::*;
#(
   parameter int           W       = 8,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         half_i,
   input  slot_e        ph_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_width
      $error("ddr_rc_lane2t: W must be at least 1");
   end

   logic         load;
   logic [W-1:0] q_q;

   assign load = !half_i || (ph_i == SLOT_SECOND);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         q_q <= RST_VAL;
      end else if (load) begin
         q_q <= d_i;
      end
   end

   assign q_o = q_q;

   // R2
   hold_two_cycles_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (half_i && ph_i == SLOT_FIRST) |=> $stable(q_o));

endmodule

// File: rtl/ddr_rc_pulse.sv
module ddr_rc_pulse
   import ddr_rc_pkg::*;
#(
   parameter int N          = 1,
   parameter bit ACTIVE_LOW = 1'b0,
   parameter bit LATE       = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic         half_i,
   input  slot_e        ph_i,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] pin_o
);

   if (N < 1) begin : g_bad_count
      $error("ddr_rc_pulse: N must be at least 1");
   end

   logic [N-1:0] act_q;

   if (LATE) begin : g_late
      // Request waits one memory cycle, then pulses in the second slot
      logic [N-1:0] held_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            act_q  <= '0;
            held_q <= '0;
         end else if (!half_i) begin
            act_q  <= req_i;
         end else if (ph_i == SLOT_SECOND) begin
            held_q <= req_i;
            act_q  <= '0;
         end else begin
            act_q  <= held_q;
         end
      end
   end else begin : g_early
      // Request pulses in the first slot of the window
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            act_q <= '0;
         end else if (!half_i) begin
            act_q <= req_i;
         end else if (ph_i == SLOT_SECOND) begin
            act_q <= req_i;
         end else begin
            act_q <= '0;
         end
      end
   end

   if (ACTIVE_LOW) begin : g_low
      assign pin_o = ~act_q;
   end else begin : g_high
      assign pin_o = act_q;
   end

   // R3
   single_cycle_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (half_i && |act_q) |=> (!half_i || ((act_q & $past(act_q)) == '0)));

   // R3
   pulse_slot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (half_i && $past(half_i) && |act_q) |->
         (ph_i == (LATE ? SLOT_SECOND : SLOT_FIRST)));

endmodule

// File: rtl/ddr_cmd_rate_conv.sv
module ddr_cmd_rate_conv
   import ddr_rc_pkg::*;
#(
   parameter int ADDR_W     = 14,
   parameter int BA_W       = 3,
   parameter int RANKS      = 2,
   parameter bit PULSE_LATE = 1'b1
) (
   input  logic              clk_mem_i,
   input  logic              rst_i,
   input  logic              half_rate_i,
   input  logic [RANKS-1:0]  cs_req_i,
   input  logic              ras_n_i,
   input  logic              cas_n_i,
   input  logic              we_n_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BA_W-1:0]   ba_i,
   input  logic [RANKS-1:0]  cke_i,
   input  logic [RANKS-1:0]  odt_i,
   output logic              phase_o,
   output logic [RANKS-1:0]  mem_cs_n_o,
   output logic [RANKS-1:0]  mem_cke_o,
   output logic [RANKS-1:0]  mem_odt_o,
   output logic              mem_ras_n_o,
   output logic              mem_cas_n_o,
   output logic              mem_we_n_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [BA_W-1:0]   mem_ba_o
);

   if (ADDR_W < 1 || BA_W < 1 || RANKS < 1) begin : g_bad_param
      $error("ddr_cmd_rate_conv: widths and rank count must be positive");
   end

   localparam logic [STROBE_W-1:0] STROBE_IDLE = '1;

   slot_e               ph;
   logic                no_cmd;
   logic [STROBE_W-1:0] strobe_d;
   logic [STROBE_W-1:0] strobe_q;

   assign no_cmd   = ~|cs_req_i;
   assign strobe_d = no_cmd ? STROBE_IDLE : {ras_n_i, cas_n_i, we_n_i};

   ddr_rc_phase i_phase (
      .clk_i (clk_mem_i),
      .rst_i (rst_i),
      .ph_o  (ph)
   );

   ddr_rc_lane2t #(.W(ADDR_W), .RST_VAL('0)) i_addr_lane (
      .clk_i  (clk_mem_i),
      .rst_i  (rst_i),
      .half_i (half_rate_i),
      .ph_i   (ph),
      .d_i    (addr_i),
      .q_o    (mem_addr_o)
   );

   ddr_rc_lane2t #(.W(BA_W), .RST_VAL('0)) i_ba_lane (
      .clk_i  (clk_mem_i),
      .rst_i  (rst_i),
      .half_i (half_rate_i),
      .ph_i   (ph),
      .d_i    (ba_i),
      .q_o    (mem_ba_o)
   );

   ddr_rc_lane2t #(.W(STROBE_W), .RST_VAL(STROBE_IDLE)) i_strobe_lane (
      .clk_i  (clk_mem_i),
      .rst_i  (rst_i),
      .half_i (half_rate_i),
      .ph_i   (ph),
      .d_i    (strobe_d),
      .q_o    (strobe_q)
   );

   ddr_rc_pulse #(.N(RANKS), .ACTIVE_LOW(1'b1), .LATE(PULSE_LATE)) i_cs_pulse (
      .clk_i  (clk_mem_i),
      .rst_i  (rst_i),
      .half_i (half_rate_i),
      .ph_i   (ph),
      .req_i  (cs_req_i),
      .pin_o  (mem_cs_n_o)
   );

   ddr_rc_pulse #(.N(RANKS), .ACTIVE_LOW(1'b0), .LATE(PULSE_LATE)) i_cke_pulse (
      .clk_i  (clk_mem_i),
      .rst_i  (rst_i),
      .half_i (half_rate_i),
      .ph_i   (ph),
      .req_i  (cke_i),
      .pin_o  (mem_cke_o)
   );

   ddr_rc_pulse #(.N(RANKS), .ACTIVE_LOW(1'b0), .LATE(PULSE_LATE)) i_odt_pulse (
      .clk_i  (clk_mem_i),
      .rst_i  (rst_i),
      .half_i (half_rate_i),
      .ph_i   (ph),
      .req_i  (odt_i),
      .pin_o  (mem_odt_o)
   );

   assign phase_o = ph;
   assign {mem_ras_n_o, mem_cas_n_o, mem_we_n_o} = strobe_q;

   // R6
   full_rate_nop_chk: assert property (@(posedge clk_mem_i) disable iff (rst_i)
      (!$past(half_rate_i) && !$past(rst_i) && (&mem_cs_n_o)) |->
         ({mem_ras_n_o, mem_cas_n_o, mem_we_n_o} == STROBE_IDLE));

   // R7
   reset_idle_chk: assert property (@(posedge clk_mem_i)
      $past(rst_i) |-> (&mem_cs_n_o && mem_cke_o == '0 && mem_odt_o == '0));

endmodule

// File: tb/test_ddr_cmd_rate_conv.sv
module test_ddr_cmd_rate_conv;

   localparam int  AW    = 14;
   localparam int  BW    = 3;
   localparam int  RK    = 2;
   localparam time TCLK  = 8ns;
   localparam int  OUT_W = 3 * RK + 3 + AW + BW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          half = 1'b1;
   logic [RK-1:0] cs_req = '0;
   logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [BW-1:0] ba = '0;
   logic [RK-1:0] cke = '0, odt = '0;
   logic          phase;
   logic [RK-1:0] m_cs_n, m_cke, m_odt;
   logic          m_ras_n, m_cas_n, m_we_n;
   logic [AW-1:0] m_addr;
   logic [BW-1:0] m_ba;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(TCLK / 2) clk = ~clk;

   ddr_cmd_rate_conv #(.ADDR_W(AW), .BA_W(BW), .RANKS(RK)) i_ddr_cmd_rate_conv (
      .clk_mem_i   (clk),
      .rst_i       (rst),
      .half_rate_i (half),
      .cs_req_i    (cs_req),
      .ras_n_i     (ras_n),
      .cas_n_i     (cas_n),
      .we_n_i      (we_n),
      .addr_i      (addr),
      .ba_i        (ba),
      .cke_i       (cke),
      .odt_i       (odt),
      .phase_o     (phase),
      .mem_cs_n_o  (m_cs_n),
      .mem_cke_o   (m_cke),
      .mem_odt_o   (m_odt),
      .mem_ras_n_o (m_ras_n),
      .mem_cas_n_o (m_cas_n),
      .mem_we_n_o  (m_we_n),
      .mem_addr_o  (m_addr),
      .mem_ba_o    (m_ba)
   );

   task automatic check(input string req, input logic [OUT_W-1:0] act,
                        input logic [OUT_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [OUT_W-1:0] outs();
      return {m_cs_n, m_cke, m_odt, m_ras_n, m_cas_n, m_we_n, m_addr, m_ba};
   endfunction

   function automatic logic [OUT_W-1:0] pack(input logic [RK-1:0] c_n,
      input logic [RK-1:0] k, input logic [RK-1:0] o, input logic [2:0] s,
      input logic [AW-1:0] a, input logic [BW-1:0] b);
      return {c_n, k, o, s, a, b};
   endfunction

   task automatic drive(input logic [RK-1:0] c, input logic [RK-1:0] k,
      input logic [RK-1:0] o, input logic [2:0] s, input logic [AW-1:0] a,
      input logic [BW-1:0] b);
      cs_req = c; cke = k; odt = o; {ras_n, cas_n, we_n} = s; addr = a; ba = b;
   endtask

   task automatic drive_nop();
      drive('0, '0, '0, 3'b111, addr, ba);
   endtask

   task automatic align_first();
      while (phase !== 1'b0) @(negedge clk);
   endtask

   function automatic logic [2:0] exp_str(input logic [RK-1:0] c, input logic [2:0] s);
      return (c == '0) ? 3'b111 : s;
   endfunction

   // Half-rate: one command, checked in both slots of its window
   task automatic t_half_cmd(input string req, input logic [RK-1:0] c,
      input logic [RK-1:0] k, input logic [RK-1:0] o, input logic [2:0] s,
      input logic [AW-1:0] a, input logic [BW-1:0] b);
      align_first();
      drive(c, k, o, s, a, b);
      @(negedge clk);
      @(negedge clk);
      check({req, " slot0"}, outs(), pack('1, '0, '0, exp_str(c, s), a, b));
      @(negedge clk);
      check({req, " slot1"}, outs(), pack(~c, k, o, exp_str(c, s), a, b));
      drive_nop();
   endtask

   task automatic t_reset();
      drive(2'b11, 2'b11, 2'b11, 3'b000, 14'h3fff, 3'h7);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R7 reset idle", outs(), pack('1, '0, '0, 3'b111, '0, '0));
      check("R7 reset phase", OUT_W'(phase), OUT_W'(0));
      drive_nop();
      rst = 1'b0;
      @(negedge clk);
      check("R1 phase after release", OUT_W'(phase), OUT_W'(1));
      @(negedge clk);
      check("R1 phase toggles to 0", OUT_W'(phase), OUT_W'(0));
      @(negedge clk);
      check("R1 phase toggles to 1", OUT_W'(phase), OUT_W'(1));
   endtask

   task automatic t_half_ignore();
      align_first();
      drive(2'b10, 2'b11, 2'b11, 3'b000, 14'h1555, 3'h5);
      @(negedge clk);
      drive(2'b01, 2'b01, 2'b00, 3'b101, 14'h0a0a, 3'h2);
      @(negedge clk);
      check("R4 phase0 values ignored slot0", outs(),
            pack('1, '0, '0, 3'b101, 14'h0a0a, 3'h2));
      @(negedge clk);
      check("R4 phase0 values ignored slot1", outs(),
            pack(2'b10, 2'b01, 2'b00, 3'b101, 14'h0a0a, 3'h2));
      drive_nop();
   endtask

   task automatic t_back_to_back();
      align_first();
      drive(2'b01, 2'b01, 2'b01, 3'b011, 14'h0123, 3'h1);
      @(negedge clk);
      @(negedge clk);
      drive(2'b10, 2'b10, 2'b00, 3'b100, 14'h2abc, 3'h6);
      check("R8 first cmd slot0", outs(), pack('1, '0, '0, 3'b011, 14'h0123, 3'h1));
      @(negedge clk);
      check("R8 first cmd slot1", outs(),
            pack(2'b10, 2'b01, 2'b01, 3'b011, 14'h0123, 3'h1));
      @(negedge clk);
      drive_nop();
      check("R8 second cmd slot0", outs(), pack('1, '0, '0, 3'b100, 14'h2abc, 3'h6));
      @(negedge clk);
      check("R8 second cmd slot1", outs(),
            pack(2'b01, 2'b10, 2'b00, 3'b100, 14'h2abc, 3'h6));
      @(negedge clk);
      check("R8 idle after pair", {m_cs_n, m_cke, m_odt, m_ras_n, m_cas_n, m_we_n},
            {2'b11, 2'b00, 2'b00, 3'b111});
   endtask

   task automatic t_full();
      @(negedge clk);
      half = 1'b0;
      drive_nop();
      repeat (3) @(negedge clk);
      drive(2'b01, 2'b01, 2'b01, 3'b010, 14'h0777, 3'h3);
      @(negedge clk);
      check("R5 full-rate cmd", outs(), pack(2'b10, 2'b01, 2'b01, 3'b010, 14'h0777, 3'h3));
      drive(2'b10, 2'b00, 2'b10, 3'b001, 14'h1111, 3'h4);
      @(negedge clk);
      check("R5 full-rate next cycle", outs(),
            pack(2'b01, 2'b00, 2'b10, 3'b001, 14'h1111, 3'h4));
      drive('0, 2'b11, 2'b00, 3'b000, 14'h0042, 3'h0);
      @(negedge clk);
      check("R6 full-rate nop forces strobes", outs(),
            pack(2'b11, 2'b11, 2'b00, 3'b111, 14'h0042, 3'h0));
      drive_nop();
      @(negedge clk);
      check("R5 full-rate one cycle only", {m_cs_n, m_cke, m_odt},
            {2'b11, 2'b00, 2'b00});
      half = 1'b1;
      drive_nop();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_half_cmd("R2 R3 rank0 activate", 2'b01, 2'b01, 2'b00, 3'b011, 14'h1234, 3'h2);
      t_half_cmd("R2 R3 rank1 write odt", 2'b10, 2'b10, 2'b10, 3'b100, 14'h0fed, 3'h7);
      t_half_cmd("R2 R3 both ranks", 2'b11, 2'b11, 2'b11, 3'b001, 14'h2001, 3'h0);
      t_half_cmd("R6 half-rate nop", 2'b00, 2'b00, 2'b00, 3'b000, 14'h0333, 3'h3);
      t_half_ignore();
      t_back_to_back();
      t_full();
      t_half_cmd("R2 R3 after mode return", 2'b01, 2'b00, 2'b01, 3'b110, 14'h3c3c, 3'h1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(TCLK * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule